// File: doc/BRIEF.md
# Dual-Mode Link Arbitration Controller

This block owns the operating mode of a display-identification memory that can either stream its contents one way, clocked by a slow stream clock, or act as a slave on a two-wire bidirectional bus. At reset the memory streams. A falling edge on the bus clock suspends streaming and puts the controller into a tentative transition mode. In that mode the bus slave listens for its own address. If the slave reports that address, the controller commits to bidirectional mode for good. If instead the stream clock pulses 128 times with no falling edge on the bus clock, the controller abandons the attempt. It then tells the streamer to restart from the most significant bit of the first memory byte.

The inputs are single-cycle, already synchronized event pulses: a bus-clock falling edge, a stream-clock pulse, and an address-match strobe from the bus slave. The outputs are three mutually exclusive mode flags, a one-cycle restart strobe for the streamer, and an enable for the bus slave.

Top module: `link_mode_ctrl`

## Requirements
- R1: After reset (synchronous, active low) the streaming flag is 1, the transition and bidirectional flags are 0, the slave enable is 0 and the restart strobe is 0.
- R2: A bus-clock falling-edge pulse while streaming moves the controller to transition mode on the next clock edge. The streaming flag then drops.
- R3: In transition mode, stream-clock pulses are counted. The 127th pulse leaves the mode unchanged. The 128th pulse returns the controller to streaming mode on the next clock edge.
- R4: Every bus-clock falling-edge pulse clears the pulse count, so the 128 pulses needed for a return must all follow the last falling edge.
- R5: On a return from transition mode to streaming, the restart strobe is 1 for exactly one clock, in the same cycle that the streaming flag rises.
- R6: An address-match pulse in transition mode moves the controller to bidirectional mode. After that, neither bus-clock falling edges nor any number of stream-clock pulses change the mode. Only reset returns it to streaming.
- R7: An address-match pulse while streaming has no effect on the mode.
- R8: When an address match and the 128th pulse arrive in the same cycle, bidirectional mode wins.
- R9: When a bus-clock falling edge and what would be the 128th pulse arrive in the same cycle, the controller stays in transition mode and the count starts again from zero.
- R10: Stream-clock pulses received while streaming are not counted toward a later return.
- R11: The slave enable is 1 in transition and bidirectional modes and 0 in streaming mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_fall_i | input | 1 | One-cycle pulse per bus-clock falling edge |
| strm_pulse_i | input | 1 | One-cycle pulse per stream-clock pulse |
| addr_hit_i | input | 1 | One-cycle pulse: bus slave received its own address |
| mode_stream_o | output | 1 | Controller is in streaming mode |
| mode_trans_o | output | 1 | Controller is in transition mode |
| mode_bidir_o | output | 1 | Controller is locked in bidirectional mode |
| strm_restart_o | output | 1 | One-cycle strobe: streamer restarts at the first bit of byte 0 |
| slave_en_o | output | 1 | Enables the bus slave |

## Verification
The bench first sits one pulse short of the return threshold and then lands exactly on it. An off-by-one counter would revert a pulse early or late. It clears the count partway through a run, which catches a counter that ignores falling edges and returns too soon. It feeds stream pulses while streaming, which catches a counter that keeps running outside transition mode. It then drives the two same-cycle collisions, address match against the final pulse and falling edge against the final pulse, where a wrong priority leaves the wrong mode. The bench also tries to leave bidirectional mode and watches the restart strobe's width. A leaky lock or a held strobe would then show up at the ports.

// File: rtl/link_mode_pkg.sv
// Shared types for the link mode controller.
// Assumes: three operating modes, encoded one per state.
package link_mode_pkg;
    typedef enum logic [1:0] {
        LM_STREAM = 2'd0,
        LM_TRANS  = 2'd1,
        LM_BIDIR  = 2'd2
    } lm_mode_t;
endpackage

// File: rtl/lm_pulse_counter.sv
// Counts stream-clock pulses while enabled and flags the pulse that reaches
// the return threshold. Assumes input pulses last one clock. The count
// returns to zero on clear, when disabled, or after the threshold pulse.
module lm_pulse_counter #(
    parameter int REVERT_CNT = 128,
    localparam int CNT_W = $clog2(REVERT_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic clear_i,
    input  logic pulse_i,
    output logic hit_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REVERT_CNT - 1);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             inc;

    // Decide whether this cycle's pulse counts and whether it is the last one.
    always_comb begin
        inc   = active_i && !clear_i && pulse_i;
        hit_o = inc && (cnt_q == LAST);
    end

    // Count register: clears, saturates, and rewinds after the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || clear_i || hit_o) cnt_q <= '0;
        else if (inc && cnt_q != MAXV)             cnt_q <= cnt_q + 1'b1;
    end

    // R4: a clear always leaves a zero count.
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
    // R3: the count never reaches the threshold value itself.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R10: nothing accumulates outside transition mode.
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/lm_mode_fsm.sv
// Mode state machine: streaming, tentative transition, permanent bidirectional.
// Assumes: event inputs are one-cycle pulses, and revert_i comes from the
// pulse counter. An address match outranks a revert in the same cycle.
module lm_mode_fsm
    import link_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bus_fall_i,
    input  logic     addr_hit_i,
    input  logic     revert_i,
    output lm_mode_t mode_o,
    output logic     restart_o
);
    lm_mode_t state_q, state_d;
    logic     restart_d;

    // Next-state logic with the address match taking priority over a revert.
    always_comb begin
        state_d   = state_q;
        restart_d = 1'b0;
        unique case (state_q)
            LM_STREAM: if (bus_fall_i) state_d = LM_TRANS;
            LM_TRANS: begin
                if (addr_hit_i) state_d = LM_BIDIR;
                else if (revert_i) begin
                    state_d   = LM_STREAM;
                    restart_d = 1'b1;
                end
            end
            LM_BIDIR:  state_d = LM_BIDIR;
            default:   state_d = LM_STREAM;
        endcase
    end

    // State and restart strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LM_STREAM;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_q <= restart_d;
        end
    end

    logic restart_q;
    assign mode_o    = state_q;
    assign restart_o = restart_q;

    // R6: bidirectional mode is never left without reset.
    p_bidir_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LM_BIDIR) |=> (state_q == LM_BIDIR));
    // R5: the restart strobe lasts one cycle.
    p_restart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q);
    // R5: the strobe comes only with the streaming state.
    p_restart_in_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> (state_q == LM_STREAM));
endmodule

// File: rtl/link_mode_ctrl.sv
// Top of the link mode controller: ties the pulse counter to the mode FSM
// and drives the mode flags, the streamer restart strobe and the slave enable.
// Assumes: all inputs are synchronous single-cycle event pulses.
module link_mode_ctrl
    import link_mode_pkg::*;
#(
    parameter int REVERT_CNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_fall_i,
    input  logic strm_pulse_i,
    input  logic addr_hit_i,
    output logic mode_stream_o,
    output logic mode_trans_o,
    output logic mode_bidir_o,
    output logic strm_restart_o,
    output logic slave_en_o
);
    lm_mode_t mode;
    logic     revert;

    lm_pulse_counter #(.REVERT_CNT(REVERT_CNT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (mode == LM_TRANS),
        .clear_i  (bus_fall_i),
        .pulse_i  (strm_pulse_i),
        .hit_o    (revert)
    );

    lm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_fall_i (bus_fall_i),
        .addr_hit_i (addr_hit_i),
        .revert_i   (revert),
        .mode_o     (mode),
        .restart_o  (strm_restart_o)
    );

    // Decode the mode into flags and the slave enable.
    always_comb begin
        mode_stream_o = (mode == LM_STREAM);
        mode_trans_o  = (mode == LM_TRANS);
        mode_bidir_o  = (mode == LM_BIDIR);
        slave_en_o    = (mode != LM_STREAM);
    end

    // R1: exactly one mode flag is ever set.
    p_one_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_stream_o, mode_trans_o, mode_bidir_o}) == 1);
    // R7: an address match while streaming never locks the mode.
    p_stream_ignores_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stream_o && addr_hit_i) |=> !mode_bidir_o);
    // R2: a bus-clock falling edge while streaming enters transition mode.
    p_fall_enters_trans_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stream_o && bus_fall_i) |=> mode_trans_o);
endmodule

// File: tb/sim_link_mode_ctrl.sv
module sim_link_mode_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_fall = 1'b0, strm = 1'b0, addr = 1'b0;
    logic m_s, m_t, m_b, rst_o, sen;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    link_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_fall_i(bus_fall), .strm_pulse_i(strm),
        .addr_hit_i(addr), .mode_stream_o(m_s), .mode_trans_o(m_t),
        .mode_bidir_o(m_b), .strm_restart_o(rst_o), .slave_en_o(sen)
    );

    localparam logic [2:0] E_STREAM = 3'b100, E_TRANS = 3'b010, E_BIDIR = 3'b001;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic chk_mode(input logic [2:0] exp, input string what);
        chk({5'd0, m_s, m_t, m_b}, {5'd0, exp}, what);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        bus_fall = 0; strm = 0; addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle event pulses driven on negedges; return at the negedge after capture.
    task automatic fall_pulse();
        bus_fall = 1'b1; @(negedge clk); bus_fall = 1'b0;
    endtask
    task automatic addr_pulse();
        addr = 1'b1; @(negedge clk); addr = 1'b0;
    endtask
    task automatic strm_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            if (i != 0) @(negedge clk);
            strm = 1'b1; @(negedge clk); strm = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk_mode(E_STREAM, "R1 mode after reset");
        chk(sen, 0, "R1 slave enable after reset");
        chk(rst_o, 0, "R1 restart after reset");
    endtask

    task automatic t_revert();
        do_reset();
        fall_pulse();
        chk_mode(E_TRANS, "R2 enter transition");
        chk(sen, 1, "R11 slave enabled in transition");
        @(negedge clk);
        strm_pulses(127);
        chk_mode(E_TRANS, "R3 127 pulses no revert");
        @(negedge clk);
        strm_pulses(1);
        chk_mode(E_STREAM, "R3 128th pulse reverts");
        chk(rst_o, 1, "R5 restart with revert");
        chk(sen, 0, "R11 slave disabled after revert");
        @(negedge clk);
        chk(rst_o, 0, "R5 restart one cycle");
        fall_pulse();
        chk_mode(E_TRANS, "R2 re-enter transition");
    endtask

    task automatic t_clear();
        do_reset();
        fall_pulse();
        strm_pulses(100);
        fall_pulse();
        strm_pulses(127);
        chk_mode(E_TRANS, "R4 count cleared by falling edge");
        strm_pulses(1);
        chk_mode(E_STREAM, "R4 revert 128 after clear");
    endtask

    task automatic t_stream_pulses();
        do_reset();
        strm_pulses(200);
        chk_mode(E_STREAM, "R10 pulses while streaming");
        chk(rst_o, 0, "R10 no restart while streaming");
        fall_pulse();
        strm_pulses(127);
        chk_mode(E_TRANS, "R10 earlier pulses not counted");
    endtask

    task automatic t_lock();
        do_reset();
        addr_pulse();
        chk_mode(E_STREAM, "R7 address ignored while streaming");
        fall_pulse();
        addr_pulse();
        chk_mode(E_BIDIR, "R6 address locks bidirectional");
        chk(sen, 1, "R11 slave enabled in bidirectional");
        fall_pulse();
        strm_pulses(300);
        chk_mode(E_BIDIR, "R6 lock survives edges and pulses");
        chk(rst_o, 0, "R6 no restart in bidirectional");
        do_reset();
        chk_mode(E_STREAM, "R6 reset leaves bidirectional");
    endtask

    task automatic t_collide_addr();
        do_reset();
        fall_pulse();
        strm_pulses(127);
        strm = 1'b1; addr = 1'b1;
        @(negedge clk);
        strm = 1'b0; addr = 1'b0;
        chk_mode(E_BIDIR, "R8 address beats revert");
        chk(rst_o, 0, "R8 no restart on address");
    endtask

    task automatic t_collide_fall();
        do_reset();
        fall_pulse();
        strm_pulses(127);
        strm = 1'b1; bus_fall = 1'b1;
        @(negedge clk);
        strm = 1'b0; bus_fall = 1'b0;
        chk_mode(E_TRANS, "R9 falling edge beats revert");
        strm_pulses(127);
        chk_mode(E_TRANS, "R9 count restarted");
        strm_pulses(1);
        chk_mode(E_STREAM, "R9 revert after fresh 128");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_revert();
        t_clear();
        t_stream_pulses();
        t_lock();
        t_collide_addr();
        t_collide_fall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule